// File: doc/BRIEF.md
# Multi-source interrupt command-mask aggregator

This block merges the interrupt requests of one overview unit and a set of channel cores into a single host interrupt line. Every source has an event counter that advances by one for each event pulse on its input. The counter value is visible to the host. A source is pending while its counter differs from the acknowledged value that the host last wrote for it. The host clears a pending source by writing back the counter value it has just handled.

Masking uses command writes rather than a stored mask word. One write carries a 2-bit command for every source. Each command can leave that source alone, unmask it or mask it. The host can therefore change one source without knowing the mask state of the others. The interrupt output is a registered level: it is high while at least one unmasked source is pending. For cores, the low bits of the counter double as the head index of that core's message ring, and the block brings that index out.

Top module: `irq_cmdmask_aggregator`

## Requirements
- R1: After a synchronous active-low reset, every source is masked, every event counter and every acknowledged value is zero, no source is pending and `irq_o` is low.
- R2: A mask write applies the 2-bit field at bits [2i+1:2i] of `mask_cmd_i` to source i. Source 0 is the overview unit and source i+1 is core i. Field value 2'b01 unmasks the source, 2'b10 masks it, and 2'b00 and 2'b11 leave its mask bit unchanged. The new mask state shows on `mask_o` after the clock edge that takes the write.
- R3: A single mask write of 0x55555555 unmasks all 16 sources of the default configuration at once, and a write of 0xAAAAAAAA masks them all.
- R4: Each clock edge with `evt_i[i]` high raises source i's counter by one, modulo 2^CNT_W. Sources that have events in the same cycle count independently. Counter i is published on `evt_cnt_o[i*CNT_W +: CNT_W]`.
- R5: `pending_o[i]` is high exactly while counter i differs from the acknowledged value of source i.
- R6: An acknowledge write stores `ack_cnt_i` as the acknowledged value of the source chosen by `ack_sel_i`. Writing the current counter value clears pending. Writing a stale value leaves pending set. If an event arrives in the same cycle as the acknowledge, that event is not lost and the source stays pending.
- R7: `ring_head_o[c*HEAD_W +: HEAD_W]` equals the low HEAD_W bits of the counter of core c, which is source c+1.
- R8: `irq_o` is the OR over all sources of (pending and not masked), registered. It follows a change of mask or pending state one clock edge later.
- R9: Events on a masked source still advance its counter and make it pending without raising `irq_o`. Unmasking the source later raises `irq_o`.
- R10: When the counter wraps back to the acknowledged value, the source stops being pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_CORES+1 | Event pulse per source, one count per cycle high |
| mask_we_i | input | 1 | Mask command write strobe |
| mask_cmd_i | input | 2*(NUM_CORES+1) | Packed 2-bit commands, field i for source i |
| ack_we_i | input | 1 | Acknowledge write strobe |
| ack_sel_i | input | clog2(NUM_CORES+1) | Source index of the acknowledge write |
| ack_cnt_i | input | CNT_W | Acknowledged counter value |
| evt_cnt_o | output | (NUM_CORES+1)*CNT_W | Published event counters, source i in slice i |
| ring_head_o | output | NUM_CORES*HEAD_W | Ring head index of each core |
| pending_o | output | NUM_CORES+1 | Pending flag per source |
| mask_o | output | NUM_CORES+1 | Current mask state per source, 1 = masked |
| irq_o | output | 1 | Level host interrupt |

## Verification
The counter, acknowledge and mask registers are all visible at the ports. A corrupted counter shows up on `evt_cnt_o` and `ring_head_o` in the cycle after the bad edge. A wrong acknowledge register shows up as a `pending_o` flag that does not match the host's own count. A mask cell that decodes a no-op command as an action changes `mask_o` right after the write. Faults in the merge logic show on `irq_o` one edge after the state it should follow. The directed tests put a masked source in the pending state, send events and acknowledges in the same cycle, and wrap a counter, so that such faults reach the ports within one or two cycles.

// File: rtl/irqagg_pkg.sv
// Shared types for the interrupt command-mask aggregator.
// Assumes: the mask command encoding is fixed at 2 bits per source.
package irqagg_pkg;

    // Per-source mask command; both idle codes leave the mask bit alone.
    typedef enum logic [1:0] {
        CMD_IDLE_LO = 2'b00,
        CMD_UNMASK  = 2'b01,
        CMD_MASK    = 2'b10,
        CMD_IDLE_HI = 2'b11
    } mask_cmd_e;

    localparam int unsigned CMD_W = 2;

endpackage

// File: rtl/irqagg_src_cnt.sv
// One interrupt source: an event counter, the value the host last
// acknowledged, and the pending flag derived from the two.
// Assumes: at most one event per cycle; the counter wraps silently.
module irqagg_src_cnt #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             ack_we_i,
    input  logic [CNT_W-1:0] ack_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pending_o
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ack_q;

    // Event counter: one step per event pulse, modulo 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (evt_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Acknowledged value: loaded by the host write for this source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= '0;
        end else if (ack_we_i) begin
            ack_q <= ack_val_i;
        end
    end

    // Pending while the published count is ahead of the acknowledge.
    always_comb begin
        pending_o = (cnt_q != ack_q);
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/irqagg_mask_cell.sv
// Mask bit of one source, updated by a 2-bit command on each write.
// Assumes: comes out of reset masked; idle commands keep the state.
module irqagg_mask_cell
    import irqagg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_we_i,
    input  logic [CMD_W-1:0] cmd_i,
    output logic             masked_o
);

    mask_cmd_e cmd;
    logic      masked_q;

    // Decode the raw field into the command type.
    always_comb begin
        cmd = mask_cmd_e'(cmd_i);
    end

    // Mask state: set or cleared only by the two active commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masked_q <= 1'b1;
        end else if (cmd_we_i) begin
            case (cmd)
                CMD_UNMASK: masked_q <= 1'b0;
                CMD_MASK:   masked_q <= 1'b1;
                default:    masked_q <= masked_q;
            endcase
        end
    end

    assign masked_o = masked_q;

endmodule

// File: rtl/irqagg_irq_merge.sv
// Merges per-source pending and mask state into one registered
// level interrupt.
// Assumes: inputs come from registers; one cycle of latency is allowed.
module irqagg_irq_merge #(
    parameter int unsigned NSRC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pending_i,
    input  logic [NSRC-1:0] masked_i,
    output logic            irq_o
);

    logic [NSRC-1:0] live;
    logic            irq_q;

    // A source drives the line when it is pending and unmasked.
    always_comb begin
        live = pending_i & ~masked_i;
    end

    // Registered OR so that the host line is free of glitches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |live;
        end
    end

    assign irq_o = irq_q;

endmodule

// File: rtl/irq_cmdmask_aggregator.sv
// Top: overview unit (source 0) plus NUM_CORES channel cores
// (source c+1). Each source has a counter with an acknowledge, a
// command-driven mask bit, and feeds one level interrupt.
// Assumes: HEAD_W <= CNT_W; writes to an index >= NSRC are dropped.
module irq_cmdmask_aggregator
    import irqagg_pkg::*;
#(
    parameter  int unsigned NUM_CORES = 15,
    parameter  int unsigned CNT_W     = 10,
    parameter  int unsigned HEAD_W    = 8,
    localparam int unsigned NSRC      = NUM_CORES + 1,
    localparam int unsigned SEL_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSRC-1:0]         evt_i,
    input  logic                    mask_we_i,
    input  logic [CMD_W*NSRC-1:0]   mask_cmd_i,
    input  logic                    ack_we_i,
    input  logic [SEL_W-1:0]        ack_sel_i,
    input  logic [CNT_W-1:0]        ack_cnt_i,
    output logic [NSRC*CNT_W-1:0]   evt_cnt_o,
    output logic [NUM_CORES*HEAD_W-1:0] ring_head_o,
    output logic [NSRC-1:0]         pending_o,
    output logic [NSRC-1:0]         mask_o,
    output logic                    irq_o
);

    logic [NSRC-1:0] ack_hit;

    // One counter, acknowledge and mask cell per source.
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        // Steer the acknowledge strobe to the selected source only.
        always_comb begin
            ack_hit[s] = ack_we_i && (ack_sel_i == SEL_W'(s));
        end

        irqagg_src_cnt #(
            .CNT_W (CNT_W)
        ) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt_i     (evt_i[s]),
            .ack_we_i  (ack_hit[s]),
            .ack_val_i (ack_cnt_i),
            .cnt_o     (evt_cnt_o[s*CNT_W +: CNT_W]),
            .pending_o (pending_o[s])
        );

        irqagg_mask_cell u_mask (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd_we_i (mask_we_i),
            .cmd_i    (mask_cmd_i[s*CMD_W +: CMD_W]),
            .masked_o (mask_o[s])
        );
    end

    // Core ring head indices: low bits of each core's counter.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_head
        assign ring_head_o[c*HEAD_W +: HEAD_W] =
            evt_cnt_o[(c+1)*CNT_W +: HEAD_W];
    end

    irqagg_irq_merge #(
        .NSRC (NSRC)
    ) u_merge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (pending_o),
        .masked_i  (mask_o),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/irq_cmdmask_aggregator_chk.sv
// Port-level properties of the aggregator, bound to the top module.
module irq_cmdmask_aggregator_chk #(
    parameter  int unsigned NUM_CORES = 15,
    parameter  int unsigned CNT_W     = 10,
    parameter  int unsigned HEAD_W    = 8,
    localparam int unsigned NSRC      = NUM_CORES + 1,
    localparam int unsigned SEL_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [NSRC-1:0]             evt_i,
    input logic                        mask_we_i,
    input logic [2*NSRC-1:0]           mask_cmd_i,
    input logic                        ack_we_i,
    input logic [SEL_W-1:0]            ack_sel_i,
    input logic [CNT_W-1:0]            ack_cnt_i,
    input logic [NSRC*CNT_W-1:0]       evt_cnt_o,
    input logic [NSRC-1:0]             pending_o,
    input logic [NSRC-1:0]             mask_o,
    input logic                        irq_o
);

    // R1: a reset cycle leaves everything masked and the line low.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (mask_o == {NSRC{1'b1}}) && !irq_o && (pending_o == '0));

    // R8: the line follows unmasked pending state one edge later.
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(pending_o & ~mask_o))));

    for (genvar s = 0; s < NSRC; s++) begin : g_chk
        // R2: idle commands leave the mask bit unchanged.
        a_r2_idle_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_we_i && (mask_cmd_i[2*s +: 2] == 2'b00 ||
                           mask_cmd_i[2*s +: 2] == 2'b11))
            |=> $stable(mask_o[s]));

        // R2: the unmask command clears the mask bit.
        a_r2_unmask_cmd: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_we_i && mask_cmd_i[2*s +: 2] == 2'b01) |=> !mask_o[s]);

        // R2: the mask command sets the mask bit.
        a_r2_mask_cmd: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_we_i && mask_cmd_i[2*s +: 2] == 2'b10) |=> mask_o[s]);

        // R4: an event advances the published counter by one.
        a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[s] |=> (evt_cnt_o[s*CNT_W +: CNT_W] ==
                          $past(evt_cnt_o[s*CNT_W +: CNT_W]) + CNT_W'(1)));

        // R4: without an event the counter holds.
        a_r4_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !evt_i[s] |=> $stable(evt_cnt_o[s*CNT_W +: CNT_W]));

        // R6: acknowledging the current count with no new event clears pending.
        a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_we_i && ack_sel_i == SEL_W'(s) && !evt_i[s] &&
             ack_cnt_i == evt_cnt_o[s*CNT_W +: CNT_W]) |=> !pending_o[s]);

        // R6: an event in the acknowledge cycle keeps the source pending.
        a_r6_ack_race: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_we_i && ack_sel_i == SEL_W'(s) && evt_i[s] &&
             ack_cnt_i == evt_cnt_o[s*CNT_W +: CNT_W]) |=> pending_o[s]);
    end

endmodule

bind irq_cmdmask_aggregator irq_cmdmask_aggregator_chk #(
    .NUM_CORES (NUM_CORES),
    .CNT_W     (CNT_W),
    .HEAD_W    (HEAD_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .mask_we_i  (mask_we_i),
    .mask_cmd_i (mask_cmd_i),
    .ack_we_i   (ack_we_i),
    .ack_sel_i  (ack_sel_i),
    .ack_cnt_i  (ack_cnt_i),
    .evt_cnt_o  (evt_cnt_o),
    .pending_o  (pending_o),
    .mask_o     (mask_o),
    .irq_o      (irq_o)
);

// File: tb/irq_cmdmask_aggregator_tb.sv
// Directed bench: one task per scenario, each checking its own results.
module irq_cmdmask_aggregator_tb;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NUM_CORES  = 15;
    localparam int unsigned CNT_W      = 10;
    localparam int unsigned HEAD_W     = 8;
    localparam int unsigned NSRC       = NUM_CORES + 1;
    localparam int unsigned SEL_W      = $clog2(NSRC);

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic [NSRC-1:0]             evt = '0;
    logic                        mask_we = 1'b0;
    logic [2*NSRC-1:0]           mask_cmd = '0;
    logic                        ack_we = 1'b0;
    logic [SEL_W-1:0]            ack_sel = '0;
    logic [CNT_W-1:0]            ack_cnt = '0;
    logic [NSRC*CNT_W-1:0]       evt_cnt;
    logic [NUM_CORES*HEAD_W-1:0] ring_head;
    logic [NSRC-1:0]             pending;
    logic [NSRC-1:0]             mask;
    logic                        irq;

    int checks = 0;
    int fails  = 0;
    int model_cnt [NSRC];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_cmdmask_aggregator #(
        .NUM_CORES (NUM_CORES),
        .CNT_W     (CNT_W),
        .HEAD_W    (HEAD_W)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt),
        .mask_we_i   (mask_we),
        .mask_cmd_i  (mask_cmd),
        .ack_we_i    (ack_we),
        .ack_sel_i   (ack_sel),
        .ack_cnt_i   (ack_cnt),
        .evt_cnt_o   (evt_cnt),
        .ring_head_o (ring_head),
        .pending_o   (pending),
        .mask_o      (mask),
        .irq_o       (irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // One clock edge; inputs change and outputs are sampled at negedges.
    task automatic tick();
        @(negedge clk);
    endtask

    function automatic logic [CNT_W-1:0] cnt_of(input int s);
        return evt_cnt[s*CNT_W +: CNT_W];
    endfunction

    task automatic mask_write(input logic [2*NSRC-1:0] word);
        mask_we  = 1'b1;
        mask_cmd = word;
        tick();
        mask_we  = 1'b0;
        mask_cmd = '0;
    endtask

    task automatic pulse(input logic [NSRC-1:0] which);
        evt = which;
        tick();
        evt = '0;
        for (int s = 0; s < NSRC; s++)
            if (which[s]) model_cnt[s] = (model_cnt[s] + 1) % (1 << CNT_W);
    endtask

    task automatic ack_write(input int s, input int val);
        ack_we  = 1'b1;
        ack_sel = SEL_W'(s);
        ack_cnt = CNT_W'(val);
        tick();
        ack_we  = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        for (int s = 0; s < NSRC; s++) model_cnt[s] = 0;
        tick();
        check("R1 mask", 64'(mask), 64'({NSRC{1'b1}}));
        check("R1 pending", 64'(pending), 64'd0);
        check("R1 irq", 64'(irq), 64'd0);
        check("R1 counters", 64'(|evt_cnt), 64'd0);
    endtask

    task automatic t_mask_cmds();
        // Unmask source 3 only (field 3 = 01).
        mask_write(32'h0000_0040);
        check("R2 unmask src3", 64'(mask), 64'hFFF7);
        // Field 3 = 11 and field 0 = 00 elsewhere: no change.
        mask_write(32'h0000_00C0);
        check("R2 idle 11 keeps", 64'(mask), 64'hFFF7);
        // Field 3 = 10 masks it again, field 15 (core 14) = 01 unmasks.
        mask_write(32'h4000_0080);
        check("R2 mask src3 unmask src15", 64'(mask), 64'h7FFF);
        mask_write(32'h8000_0000);
        check("R2 remask src15", 64'(mask), 64'hFFFF);
    endtask

    task automatic t_all();
        mask_write(32'h5555_5555);
        check("R3 unmask all", 64'(mask), 64'h0000);
        mask_write(32'hAAAA_AAAA);
        check("R3 mask all", 64'(mask), 64'hFFFF);
    endtask

    task automatic t_masked_events();
        pulse(16'h0021);
        pulse(16'h0020);
        pulse(16'h0020);
        check("R4 src0 count", 64'(cnt_of(0)), 64'(model_cnt[0]));
        check("R4 src5 count", 64'(cnt_of(5)), 64'(model_cnt[5]));
        check("R4 src6 idle", 64'(cnt_of(6)), 64'd0);
        check("R7 core4 head", 64'(ring_head[4*HEAD_W +: HEAD_W]), 64'd3);
        check("R5 pending set", 64'(pending), 64'h0021);
        tick();
        check("R9 masked no irq", 64'(irq), 64'd0);
        // Unmask source 5 (field 5 = 01).
        mask_write(32'h0000_0400);
        check("R8 irq one edge late", 64'(irq), 64'd0);
        tick();
        check("R9 irq after unmask", 64'(irq), 64'd1);
    endtask

    task automatic t_ack();
        ack_write(5, 2);
        check("R6 stale ack keeps pending", 64'(pending[5]), 64'd1);
        ack_write(5, model_cnt[5]);
        check("R6 ack clears", 64'(pending[5]), 64'd0);
        check("R8 irq still high", 64'(irq), 64'd1);
        tick();
        check("R8 irq falls", 64'(irq), 64'd0);
        // Event on source 0 in the same cycle as its acknowledge.
        evt[0] = 1'b1;
        ack_write(0, model_cnt[0]);
        evt[0] = 1'b0;
        model_cnt[0] = model_cnt[0] + 1;
        check("R6 race count", 64'(cnt_of(0)), 64'(model_cnt[0]));
        check("R6 race pending", 64'(pending[0]), 64'd1);
        ack_write(0, model_cnt[0]);
        check("R6 ack after race", 64'(pending[0]), 64'd0);
    endtask

    task automatic t_wrap();
        for (int k = 0; k < (1 << CNT_W) - 1; k++) pulse(16'h0080);
        check("R4 near wrap", 64'(cnt_of(7)), 64'((1 << CNT_W) - 1));
        check("R7 core6 head low bits", 64'(ring_head[6*HEAD_W +: HEAD_W]), 64'hFF);
        check("R5 pending before wrap", 64'(pending[7]), 64'd1);
        pulse(16'h0080);
        check("R10 wrapped count", 64'(cnt_of(7)), 64'd0);
        check("R10 wrap clears pending", 64'(pending[7]), 64'd0);
    endtask

    initial begin
        tick();
        t_reset();
        t_mask_cmds();
        t_all();
        t_masked_events();
        t_ack();
        t_wrap();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule